// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects interrupt requests from the peripherals of a register window and presents a single request line to the processor. Each peripheral sets its own bit in a 32-bit pending-status register with a one-cycle pulse. Software picks which pending bits may interrupt by writing an enable mask, and it clears serviced bits by writing the status register. That write keeps only the bits written as one that are also enabled. Two configuration inputs hold a serial-link bit (bit 7) and an audio bit (bit 9) high. They apply at reset and again in front of every status write. The DMA engine reports completion through status bit 3.

Both registers accept 16-bit writes, which touch only the lower half-word, and 32-bit writes. The status register sits at window offset 0x070 and the mask at 0x074. When a new mask uncovers bits that are already pending, a one-cycle pending-check pulse tells the processor side to look for interrupts again.

Top module: `irq_status_ctrl`

## Requirements
- R1: While rst_ni is low, status holds bit 7 equal to ser_force_i, bit 9 equal to aud_force_i and all other bits zero. The mask is zero and irq_o and pend_chk_o are low.
- R2: A 32-bit write (wr_wide_i=1) to offset 0x070 makes status equal to (status OR forced bits) AND mask AND wr_data_i.
- R3: The forced bits are bit 7 when ser_force_i is high and bit 9 when aud_force_i is high. A status write keeps a forced bit when the mask and the written data both have it set, even if it was not pending before.
- R4: A 32-bit write to offset 0x074 stores wr_data_i in the mask unchanged.
- R5: A 16-bit write (wr_wide_i=0) to either register changes only bits 15:0, and bits 31:16 keep their value.
- R6: A high bit of set_i sets the same status bit at the next clock edge. When a status write happens in the same cycle, the set wins and the bit stays pending.
- R7: irq_o is a register that holds the OR of (status AND mask) as it stood one clock earlier.
- R8: pend_chk_o is high for exactly the one cycle after a mask write in which the old status AND the new mask value is nonzero. At any other time it is low.
- R9: rd_data_o returns the status at offset 0x070, the mask at 0x074 and zero at any other offset. A read changes no state.
- R10: Writes to any other offset leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_force_i | input | 1 | Holds status bit 7 high at reset and before each status write |
| aud_force_i | input | 1 | Holds status bit 9 high at reset and before each status write |
| set_i | input | 32 | One-cycle pulses, one per status bit |
| wr_en_i | input | 1 | Write strobe |
| wr_wide_i | input | 1 | 1 = 32-bit write, 0 = 16-bit write (bits 15:0 only) |
| addr_i | input | 12 | Offset within the register window |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered interrupt request |
| pend_chk_o | output | 1 | One-cycle pulse: a new mask uncovers pending bits |

## Verification
The assertions check the following on every cycle:
- a set pulse always lands in status;
- a status write without set pulses never raises a bit that was neither pending nor forced;
- a 16-bit write keeps the upper halves;
- a 32-bit mask write stores its data;
- irq_o trails status AND mask by one cycle;
- pend_chk_o only follows a mask write.

Only the bench's scenarios can show the rest. These are the exact values after an acknowledge and the reset pattern for every setting of the two force inputs. They also include the effect of the forced bits when nothing was pending, the zero readback at unused offsets, and that writes there are ignored.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned LANES  = WORD_W / HALF_W;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
  input  logic              wr_en_i,
  input  logic              wr_wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              stat_we_o,
  output logic              mask_we_o,
  output logic [WORD_W-1:0] wmask_o
);
  logic [LANES-1:0] lane_en;

  always_comb begin
    if (addr_i == STAT_OFS)      sel_o = SEL_STAT;
    else if (addr_i == MASK_OFS) sel_o = SEL_MASK;
    else                         sel_o = SEL_NONE;
  end

  assign stat_we_o = wr_en_i && (sel_o == SEL_STAT);
  assign mask_we_o = wr_en_i && (sel_o == SEL_MASK);

  // lane 0 is always written; upper lanes only by full-width access
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    if (ln == 0) begin : g_low
      assign lane_en[ln] = 1'b1;
    end else begin : g_high
      assign lane_en[ln] = wr_wide_i;
    end
    assign wmask_o[ln*HALF_W +: HALF_W] = {HALF_W{lane_en[ln]}};
  end
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
  import irq_ctl_pkg::*;
#(
  parameter int unsigned SER_BIT = 7,
  parameter int unsigned AUD_BIT = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_force_i,
  input  logic              aud_force_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wmask_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic [WORD_W-1:0] set_i,
  output logic [WORD_W-1:0] stat_o
);
  logic [WORD_W-1:0] force_vec;
  logic [WORD_W-1:0] acked;
  logic [WORD_W-1:0] stat_d;
  logic [WORD_W-1:0] stat_q;

  always_comb begin
    force_vec          = '0;
    force_vec[SER_BIT] = ser_force_i;
    force_vec[AUD_BIT] = aud_force_i;
  end

  assign acked = (stat_q | force_vec) & mask_i & wdata_i;

  always_comb begin
    stat_d = stat_q;
    if (we_i) stat_d = (acked & wmask_i) | (stat_q & ~wmask_i);
    stat_d = stat_d | set_i;  // new events beat the acknowledge
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= force_vec;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wmask_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] stat_i,
  output logic [WORD_W-1:0] mask_o,
  output logic              chk_o
);
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] mask_new;
  logic              chk_q;

  assign mask_new = (wdata_i & wmask_i) | (mask_q & ~wmask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      chk_q  <= 1'b0;
    end else begin
      if (we_i) mask_q <= mask_new;
      chk_q <= we_i && |(stat_i & mask_new);
    end
  end

  assign mask_o = mask_q;
  assign chk_o  = chk_q;
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out
  import irq_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] stat_i,
  input  logic [WORD_W-1:0] mask_i,
  output logic              irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_i & mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074,
  parameter int unsigned SER_BIT  = 7,
  parameter int unsigned AUD_BIT  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_force_i,
  input  logic              aud_force_i,
  input  logic [WORD_W-1:0] set_i,
  input  logic              wr_en_i,
  input  logic              wr_wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              pend_chk_o
);
  reg_sel_e          sel;
  logic              stat_we;
  logic              mask_we;
  logic [WORD_W-1:0] wmask;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] mask_q;

  irq_wr_decode #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .MASK_OFS(MASK_OFS)
  ) i_decode (
    .wr_en_i  (wr_en_i),
    .wr_wide_i(wr_wide_i),
    .addr_i   (addr_i),
    .sel_o    (sel),
    .stat_we_o(stat_we),
    .mask_we_o(mask_we),
    .wmask_o  (wmask)
  );

  irq_stat_reg #(
    .SER_BIT(SER_BIT),
    .AUD_BIT(AUD_BIT)
  ) i_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ser_force_i(ser_force_i),
    .aud_force_i(aud_force_i),
    .we_i       (stat_we),
    .wmask_i    (wmask),
    .wdata_i    (wr_data_i),
    .mask_i     (mask_q),
    .set_i      (set_i),
    .stat_o     (stat_q)
  );

  irq_mask_reg i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .wmask_i(wmask),
    .wdata_i(wr_data_i),
    .stat_i (stat_q),
    .mask_o (mask_q),
    .chk_o  (pend_chk_o)
  );

  irq_req_out i_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stat_i(stat_q),
    .mask_i(mask_q),
    .irq_o (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_data_o = stat_q;
      SEL_MASK: rd_data_o = mask_q;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import irq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074,
  parameter int unsigned SER_BIT  = 7,
  parameter int unsigned AUD_BIT  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_force_i,
  input logic              aud_force_i,
  input logic [WORD_W-1:0] set_i,
  input logic              wr_en_i,
  input logic              wr_wide_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [WORD_W-1:0] stat_q,
  input logic [WORD_W-1:0] mask_q,
  input logic              irq_o,
  input logic              pend_chk_o
);
  logic [WORD_W-1:0] fvec;
  logic              stat_wr;
  logic              mask_wr;

  always_comb begin
    fvec          = '0;
    fvec[SER_BIT] = ser_force_i;
    fvec[AUD_BIT] = aud_force_i;
  end

  assign stat_wr = wr_en_i && (addr_i == STAT_OFS);
  assign mask_wr = wr_en_i && (addr_i == MASK_OFS);

  p_set_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(set_i)) == $past(set_i)));

  p_ack_no_new_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && set_i == '0) |=> ((stat_q & ~$past(stat_q | fvec)) == '0));

  p_stat_upper_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && !wr_wide_i) |=>
      (stat_q[WORD_W-1:HALF_W] == $past(stat_q[WORD_W-1:HALF_W] | set_i[WORD_W-1:HALF_W])));

  p_mask_upper_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr && !wr_wide_i) |=> $stable(mask_q[WORD_W-1:HALF_W]));

  p_mask_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr && wr_wide_i) |=> (mask_q == $past(wr_data_i)));

  p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr |=> $stable(mask_q));

  p_irq_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(stat_q & mask_q))));

  p_chk_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_chk_o |-> $past(mask_wr));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .STAT_OFS(STAT_OFS),
  .MASK_OFS(MASK_OFS),
  .SER_BIT (SER_BIT),
  .AUD_BIT (AUD_BIT)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ser_force_i(ser_force_i),
  .aud_force_i(aud_force_i),
  .set_i      (set_i),
  .wr_en_i    (wr_en_i),
  .wr_wide_i  (wr_wide_i),
  .addr_i     (addr_i),
  .wr_data_i  (wr_data_i),
  .stat_q     (stat_q),
  .mask_q     (mask_q),
  .irq_o      (irq_o),
  .pend_chk_o (pend_chk_o)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] STAT_A  = 12'h070;
  localparam logic [11:0] MASK_A  = 12'h074;
  localparam logic [11:0] OTHER_A = 12'h078;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ser_force_i = 1'b0;
  logic        aud_force_i = 1'b0;
  logic [31:0] set_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_wide_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;
  logic        pend_chk_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] m_stat, m_mask, fv;
  logic        exp_chk;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_status_ctrl i_irq_status_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_force_i(ser_force_i), .aud_force_i(aud_force_i),
    .set_i(set_i), .wr_en_i(wr_en_i), .wr_wide_i(wr_wide_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .pend_chk_o(pend_chk_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rd_data_o;
  endtask

  // called just after a falling edge
  task automatic op(bit we, bit wide, logic [11:0] a, logic [31:0] d, logic [31:0] s);
    logic [31:0] ns, nm, t;
    ns = m_stat; nm = m_mask; exp_chk = 1'b0;
    if (we && a == STAT_A) begin
      t = (m_stat | fv) & m_mask & d;
      if (!wide) t[31:16] = m_stat[31:16];
      ns = t;
    end
    if (we && a == MASK_A) begin
      nm = wide ? d : {m_mask[31:16], d[15:0]};
      exp_chk = |(m_stat & nm);
    end
    ns = ns | s;
    wr_en_i = we; wr_wide_i = wide; addr_i = a; wr_data_i = d; set_i = s;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; set_i = '0;
    m_stat = ns; m_mask = nm;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v, pa, pb, pc;
    for (int fc = 0; fc < 4; fc++) begin
      @(negedge clk_i);
      rst_ni = 1'b0;
      ser_force_i = fc[0]; aud_force_i = fc[1];
      fv = '0; fv[7] = fc[0]; fv[9] = fc[1];
      m_stat = fv; m_mask = '0;
      repeat (2) @(negedge clk_i);
      rd(STAT_A, v); check("R1 reset status", v, fv);
      rd(MASK_A, v); check("R1 reset mask", v, 32'h0);
      check("R1 reset irq", {31'b0, irq_o}, 32'h0);
      check("R1 reset pend_chk", {31'b0, pend_chk_o}, 32'h0);
      rst_ni = 1'b1;
      @(negedge clk_i);

      // R3: nothing pending, full mask, all-ones ack leaves only forced bits
      op(1, 1, MASK_A, 32'hFFFF_FFFF, 0);
      op(1, 1, STAT_A, 32'hFFFF_FFFF, 0);
      rd(STAT_A, v); check("R3 forced bits after ack", v, m_stat);
      op(1, 1, STAT_A, 32'h0, 0);
      rd(STAT_A, v); check("R2 zero ack clears", v, 32'h0);

      for (int i = 0; i < 12; i++) begin
        pa = (i + 1) * 32'h9E37_79B1 ^ (fc * 32'h0101_0101);
        pb = (i + 3) * 32'h7F4A_7C15 | 32'h0000_0288;
        pc = ~((i + 5) * 32'h6C8E_9CF5) | 32'h0001_0000;

        op(0, 0, STAT_A, 0, pa);
        rd(STAT_A, v); check("R6 set pulse", v, m_stat);

        op(1, i[0], MASK_A, pb, 0);
        check("R8 pend_chk after mask write", {31'b0, pend_chk_o}, {31'b0, exp_chk});
        rd(MASK_A, v); check(i[0] ? "R4 mask store" : "R5 mask narrow", v, m_mask);

        op(0, 0, STAT_A, 0, 0);
        check("R8 pend_chk drops", {31'b0, pend_chk_o}, 32'h0);
        check("R7 irq", {31'b0, irq_o}, {31'b0, |(m_stat & m_mask)});

        op(1, i[1], STAT_A, pc, 0);
        rd(STAT_A, v); check(i[1] ? "R2 wide ack" : "R5 narrow ack", v, m_stat);
        check("R8 no pend_chk on status write", {31'b0, pend_chk_o}, 32'h0);
        op(0, 0, STAT_A, 0, 0);
        check("R7 irq after ack", {31'b0, irq_o}, {31'b0, |(m_stat & m_mask)});

        op(1, 1, STAT_A, 32'h0, pa & 32'h00F0_0F0F);
        rd(STAT_A, v); check("R6 set beats ack", v, m_stat);

        op(1, 1, OTHER_A, ~pa, 0);
        rd(STAT_A, v); check("R10 other write status", v, m_stat);
        rd(MASK_A, v); check("R10 other write mask", v, m_mask);
        rd(OTHER_A, v); check("R9 unused offset reads zero", v, 32'h0);
        rd(STAT_A, v); check("R9 read no side effect", v, m_stat);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule